// File: doc/BRIEF.md
# Memory Cycle Sequencer with Wait States

This block carries out one memory access at a time for a small processor core. A requester presents an address, write data and a direction bit together with a request strobe. While the block is idle it takes the request and drives the memory address, the write data and exactly one of the read or write strobes. It then holds the strobes for as long as the memory keeps its ready line low.

When memory signals ready, a read latches the memory data into a response register. A write latches nothing. In both cases the block spends one closing clock with the strobes low and a done pulse high, then returns to idle.

Internally each access passes through an opening phase, zero or more wait phases and a closing phase. The memory is taken to be a simple synchronous slave. It raises ready for one clock, and read data is valid in that same clock.

Top module: `mem_cycle_seq`

## Requirements
- R1: When `req_valid` is high on a clock edge while `busy` is low, from the next cycle on `mem_addr` equals `req_addr`. In that cycle `mem_rd` is high for `req_write`=0 and `mem_wr` is high for `req_write`=1.
- R2: For an accepted write, `mem_wdata` equals `req_wdata` from the cycle after acceptance until the access completes.
- R3: While a strobe is high and `mem_ready` is low at a clock edge, the same strobe stays high and `mem_addr` is unchanged after that edge, for any number of wait clocks.
- R4: `rsp_done` goes high exactly in the cycle after the first edge at which `mem_ready` is high while a strobe is active. With `mem_ready` high at the first edge after acceptance, there are no wait cycles and `rsp_done` comes two cycles after the request edge.
- R5: A read stores the value of `mem_rdata` sampled at its ready edge into `rsp_rdata`. That value is visible while `rsp_done` is high and is held until the next read completes.
- R6: A write completes with a `rsp_done` pulse and leaves `rsp_rdata` unchanged.
- R7: `rsp_done` is high for exactly one cycle per access, and both strobes are low in that cycle.
- R8: `busy` is high from the cycle after acceptance through the `rsp_done` cycle. Requests presented while `busy` is high are ignored and change neither `mem_addr` nor the direction of the strobes.
- R9: `mem_rd` and `mem_wr` are never high together.
- R10: A clock edge with `rst_n` low puts the block in idle with `mem_rd`, `mem_wr`, `rsp_done` and `busy` low and `rsp_rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Data for a write |
| busy | output | 1 | An access is in progress |
| mem_addr | output | ADDR_W | Address to memory |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_ready | input | 1 | Memory ends the access |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ready` |
| rsp_rdata | output | DATA_W | Last read result |
| rsp_done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs reads and writes at random addresses with random wait counts from zero to five. It also runs directed accesses with zero waits and with twelve waits. Comparing zero waits against several waits separates a sequencer that counts a fixed latency from one that really follows the ready line. Interleaving writes between reads shows whether a write disturbs the held read result. During every access the bench also drives conflicting requests, which separates a design that locks its request in from one that restarts mid-cycle. A reset issued in the middle of an access checks the return to idle.

// File: rtl/mcs_pkg.sv
// Shared types for the memory cycle sequencer.
package mcs_pkg;
    // Access phase: idle, opening phase, wait phase, closing phase
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPEN = 2'd1,
        PH_WAIT = 2'd2,
        PH_DONE = 2'd3
    } mcs_phase_e;
endpackage

// File: rtl/mcs_phase_ctrl.sv
// Phase controller: steps one access through open, wait (repeated) and
// closing phases. Assumes memory ready is a synchronous, single-clock
// indication; ready is already examined at the edge ending the open phase.
module mcs_phase_ctrl
    import mcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mem_ready,
    output mcs_phase_e phase,
    output logic       accept,
    output logic       finish,
    output logic       active,
    output logic       done
);
    mcs_phase_e phase_q, phase_d;

    // Decode the handshake events from the present phase
    always_comb begin
        accept = (phase_q == PH_IDLE) && start;
        active = (phase_q == PH_OPEN) || (phase_q == PH_WAIT);
        finish = active && mem_ready;
        done   = (phase_q == PH_DONE);
    end

    // Next-phase selection
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (start) phase_d = PH_OPEN;
            PH_OPEN: phase_d = mem_ready ? PH_DONE : PH_WAIT;
            PH_WAIT: if (mem_ready) phase_d = PH_DONE;
            PH_DONE: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R7: completion marker lasts one clock
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4: a ready edge during an active phase leads straight to completion
    a_r4_ready_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mem_ready) |=> done);
endmodule

// File: rtl/mcs_bus_regs.sv
// Bus registers: hold the address, write data and direction of the access
// in progress, and keep the last read result. Assumes accept and finish
// never coincide (the phase controller guarantees this).
module mcs_bus_regs #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              finish,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              write_q,
    output logic [DATA_W-1:0] rdata_q
);
    // Latch the request when the access is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            if (req_write) wdata_q <= req_wdata;
        end
    end

    // Capture memory data at the ready edge of a read only
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (finish && !write_q) rdata_q <= mem_rdata;
    end

    // R8: the held address only moves when a new access is taken
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(addr_q));
    // R6: a finishing write keeps the read result
    a_r6_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && write_q) |=> $stable(rdata_q));
endmodule

// File: rtl/mem_cycle_seq.sv
// Memory cycle sequencer top: takes one request while idle, drives the
// memory strobes until ready, then reports completion. Assumes one
// outstanding access and a memory that never needs the strobes to drop
// between wait clocks.
module mem_cycle_seq
    import mcs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done
);
    mcs_phase_e phase;
    logic       accept, finish, active, write_q;

    mcs_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_valid),
        .mem_ready (mem_ready),
        .phase     (phase),
        .accept    (accept),
        .finish    (finish),
        .active    (active),
        .done      (rsp_done)
    );

    mcs_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .finish    (finish),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_rdata (mem_rdata),
        .addr_q    (mem_addr),
        .wdata_q   (mem_wdata),
        .write_q   (write_q),
        .rdata_q   (rsp_rdata)
    );

    // Strobes follow the active phases, steered by the held direction
    always_comb begin
        mem_rd = active && !write_q;
        mem_wr = active &&  write_q;
        busy   = (phase != PH_IDLE);
    end

    // R9: strobes never overlap
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R3: a strobe without ready persists with the address unchanged
    a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));
    a_r3_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr)));
    // R7: no strobe during the completion cycle
    a_r7_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!mem_rd && !mem_wr));
    // R10: a reset edge leaves the block idle and quiet
    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_rd && !mem_wr && !rsp_done));
endmodule

// File: tb/mem_cycle_seq_bench.sv
`timescale 1ns/1ps
module mem_cycle_seq_bench;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rd, mem_wr;
    logic          mem_ready = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [DW-1:0] exp_rdata = '0;

    always #2.5 clk = ~clk;

    mem_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) u_mem_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done)
    );

    // Expected read result after an access completes
    function automatic logic [DW-1:0] next_rdata(bit wr, logic [DW-1:0] old,
                                                 logic [DW-1:0] sampled);
        return wr ? old : sampled;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access with a given wait count; junk requests are driven meanwhile
    task automatic access(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, int waits);
        logic [DW-1:0] rd = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        chk(mem_rd == !wr && mem_wr == wr, "R1 strobe direction",
            {mem_rd, mem_wr}, {!wr, wr});
        chk(mem_addr == a, "R1 address", mem_addr, a);
        if (wr) chk(mem_wdata == d, "R2 write data", mem_wdata, d);
        req_write = !wr; req_addr = ~a; req_wdata = ~d;
        for (int k = 0; k <= waits; k++) begin
            if (k > 0) begin
                chk(mem_rd == !wr && mem_wr == wr, "R3 strobe held",
                    {mem_rd, mem_wr}, {!wr, wr});
                chk(mem_addr == a, "R3/R8 address held", mem_addr, a);
                if (wr) chk(mem_wdata == d, "R2 data held", mem_wdata, d);
            end
            chk(rsp_done == 1'b0, "R4 no early done", rsp_done, 0);
            mem_ready = (k == waits);
            rd = DW'($urandom);
            mem_rdata = rd;
            @(negedge clk);
        end
        exp_rdata = next_rdata(wr, exp_rdata, rd);
        chk(rsp_done == 1'b1, "R4 done after ready", rsp_done, 1);
        chk(!mem_rd && !mem_wr, "R7 strobes low at done", {mem_rd, mem_wr}, 0);
        chk(rsp_rdata == exp_rdata, wr ? "R6 rdata kept" : "R5 rdata captured",
            rsp_rdata, exp_rdata);
        req_valid = 1'b0; mem_ready = 1'b0;
        @(negedge clk);
        chk(rsp_done == 1'b0 && busy == 1'b0, "R7/R8 single done, idle",
            {rsp_done, busy}, 0);
        chk(rsp_rdata == exp_rdata, "R5 rdata held", rsp_rdata, exp_rdata);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk); @(negedge clk);
        chk(!busy && !mem_rd && !mem_wr && !rsp_done && rsp_rdata == '0,
            "R10 reset state", {busy, mem_rd, mem_wr, rsp_done}, 0);
        rst_n = 1'b1;
        // Directed corners
        access(1'b0, 12'h123, 16'h0, 0);
        access(1'b1, 12'h456, 16'hBEEF, 0);
        access(1'b0, 12'hFFF, 16'h0, 12);
        access(1'b1, 12'h000, 16'h1234, 12);
        // Random mix
        for (int i = 0; i < 60; i++)
            access(1'(($urandom) & 1), AW'($urandom), DW'($urandom),
                   int'($urandom_range(0, 5)));
        // Reset in the middle of a wait
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h0AA;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(mem_rd == 1'b1, "R3 waiting before reset", mem_rd, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_rd && !mem_wr && !rsp_done && rsp_rdata == '0,
            "R10 reset mid access", {busy, mem_rd, mem_wr, rsp_done}, 0);
        rst_n = 1'b1;
        exp_rdata = '0;
        access(1'b0, 12'h321, 16'h0, 2);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule